// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stopper

This block takes one source clock and drives a group of gated copies of it. An asynchronous active-low stop request and a per-output enable mask decide which copies run. Some copies can be marked free-running, and those ignore the stop request. A gated copy is only ever parked low. The gating decision changes only while the source clock is low, so every high pulse that reaches an output is a full half period.

An asynchronous active-low power-down input shuts the whole group, including the free-running copies. The request is first synchronized. Every output is then forced low on a falling edge, and only on the rising edge after that is a ready flag raised, which tells the system that oscillators may be switched off. A small state machine runs the sequence. It has three states:

- `PD_RUN`: normal operation.
- `PD_DRAIN`: outputs are being forced low.
- `PD_OFF`: all outputs are low and ready is high.

Its transitions are:

- RUN→DRAIN when the synchronized power-down is low.
- DRAIN→OFF always, after one cycle.
- OFF→RUN when the synchronized power-down returns high.

Top module: `clock_stop_gater`

## Requirements
- R1: The stop request passes through SYNC_STAGES (default 2) flops before use. With the default, a change of `stop_n` that occurs just after a falling edge of `clk` reaches the affected outputs within 3 source cycles, both when stopping and when restarting (always under 4 cycles).
- R2: No high pulse on any output is shorter than half a source period. Outputs stop only in the low state, and the first pulse after a restart is full width.
- R3: An output whose FREE_MASK bit is 1 keeps toggling whatever `stop_n` does.
- R4: An output whose `en_mask` bit is 0 is held low and does not switch. This applies to free-running outputs too.
- R5: Once the synchronized `pd_n` is low, every output is held low from the next falling edge of `clk`. `pd_ready` rises one rising edge later and is never high while any output pulses.
- R6: While power-down is in effect, `stop_n` has no effect and all outputs stay low. After `pd_n` returns high, `pd_ready` falls and the outputs resume according to `en_mask` and `stop_n`.
- R7: While `rst_n` is low, all outputs and `pd_ready` are low.
- R8: An output that is enabled, running and not in power-down produces one full high pulse in every source cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request for the non-free outputs |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| en_mask | input | N | Per-output enable, 1 = may run; synchronous to `clk` |
| gclk | output | N | Gated clock outputs |
| pd_ready | output | 1 | High when all outputs are parked low in power-down |

## Verification
The bench measures every high pulse on every output against half the source period. This catches a gate that opens or closes while the clock is high, which would produce a runt pulse on stop or restart.

Stop and restart latency are counted in whole cycles. A missing or extra synchronizer stage would show up as a latency of 2 or 4 instead of 3.

Power-down is checked in three ways:
- `pd_ready` must be seen only after the outputs are quiet, so a flag raised too early is caught.
- `stop_n` is toggled during power-down, so a free-running output that escapes the forced-low state is caught.
- After `pd_n` is released, the outputs must resume.

Random enable masks and stop levels are compared with the expected gating of each output, which catches a swapped free-running bit or a disabled output that still pulses.

// File: rtl/clock_stop_pkg.sv
package clock_stop_pkg;
    typedef enum logic [1:0] {
        PD_RUN   = 2'd0,
        PD_DRAIN = 2'd1,
        PD_OFF   = 2'd2
    } pd_state_t;
endpackage

// File: rtl/clock_stop_sync.sv
module clock_stop_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/clock_stop_pd_fsm.sv
module clock_stop_pd_fsm
    import clock_stop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_sync_n,
    output logic      hold_all,
    output logic      pd_ready,
    output pd_state_t state_o
);
    pd_state_t state_q;
    pd_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PD_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_RUN:   if (!pd_sync_n) state_d = PD_DRAIN;
            PD_DRAIN: state_d = PD_OFF;
            PD_OFF:   if (pd_sync_n) state_d = PD_RUN;
            default:  state_d = PD_RUN;
        endcase
    end

    always_comb begin
        hold_all = (state_q != PD_RUN);
        pd_ready = (state_q == PD_OFF);
        state_o  = state_q;
    end
endmodule

// File: rtl/clock_stop_gate.sv
module clock_stop_gate #(
    parameter int             N         = 4,
    parameter logic [N-1:0]   FREE_MASK = 4'b0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_sync,
    input  logic         hold_all,
    input  logic [N-1:0] en_mask,
    output logic [N-1:0] gclk
);
    logic [N-1:0] open_q;

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic open_d;
        if (FREE_MASK[i]) begin : g_free
            assign open_d = en_mask[i] & ~hold_all;
        end else begin : g_stoppable
            assign open_d = en_mask[i] & ~hold_all & run_sync;
        end

        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q[i] <= 1'b0;
            end else begin
                open_q[i] <= open_d;
            end
        end

        assign gclk[i] = clk & open_q[i];
    end
endmodule

// File: rtl/clock_stop_gater.sv
module clock_stop_gater
    import clock_stop_pkg::*;
#(
    parameter int           N           = 4,
    parameter logic [N-1:0] FREE_MASK   = 4'b0001,
    parameter int           SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_n,
    input  logic         pd_n,
    input  logic [N-1:0] en_mask,
    output logic [N-1:0] gclk,
    output logic         pd_ready
);
    logic      run_sync;
    logic      pd_sync_n;
    logic      hold_all;
    pd_state_t fsm_state;

    clock_stop_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_stop_sync (
        .clk(clk), .rst_n(rst_n), .async_in(stop_n), .sync_out(run_sync)
    );

    clock_stop_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pd_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pd_n), .sync_out(pd_sync_n)
    );

    clock_stop_pd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pd_sync_n(pd_sync_n),
        .hold_all(hold_all), .pd_ready(pd_ready), .state_o(fsm_state)
    );

    clock_stop_gate #(.N(N), .FREE_MASK(FREE_MASK)) u_gate (
        .clk(clk), .rst_n(rst_n), .run_sync(run_sync), .hold_all(hold_all),
        .en_mask(en_mask), .gclk(gclk)
    );
endmodule

// File: rtl/clock_stop_gater_chk.sv
module clock_stop_gater_chk
    import clock_stop_pkg::*;
#(
    parameter int           N         = 4,
    parameter logic [N-1:0] FREE_MASK = 4'b0001
) (
    input logic         clk,
    input logic         rst_n,
    input logic         stop_n,
    input logic [N-1:0] en_mask,
    input logic [N-1:0] gclk,
    input logic         pd_ready,
    input pd_state_t    fsm_state
);
    logic [2:0] since_rst;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 3'd0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    // Sampled at the falling edge, gclk shows the high phase that just ended.
    assert_pd_quiet_R5: assert property (@(negedge clk) disable iff (!rst_n)
        pd_ready |-> (gclk == '0));

    assert_disabled_low_R4: assert property (@(negedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2) |-> ((gclk & ~$past(en_mask)) == '0));

    assert_free_runs_R3: assert property (@(negedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2) |->
        ((gclk & FREE_MASK) == ($past(en_mask) & FREE_MASK & {N{$past(fsm_state) == PD_RUN}})));

    assert_stop_latency_R1: assert property (@(negedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd5) && !stop_n && !$past(stop_n) && !$past(stop_n, 2) && !$past(stop_n, 3))
        |-> ((gclk & ~FREE_MASK) == '0));
endmodule

bind clock_stop_gater clock_stop_gater_chk #(.N(N), .FREE_MASK(FREE_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .en_mask(en_mask),
    .gclk(gclk), .pd_ready(pd_ready), .fsm_state(fsm_state)
);

// File: tb/clock_stop_gater_test.sv
`timescale 1ns/1ps
module clock_stop_gater_test;
    localparam int           N    = 4;
    localparam logic [N-1:0] FREE = 4'b0001;
    localparam real          HALF = 2.5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_n = 1'b1;
    logic         pd_n = 1'b1;
    logic [N-1:0] en_mask = '1;
    logic [N-1:0] gclk;
    logic         pd_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(HALF) clk = ~clk;

    clock_stop_gater #(.N(N), .FREE_MASK(FREE), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .pd_n(pd_n),
        .en_mask(en_mask), .gclk(gclk), .pd_ready(pd_ready)
    );

    function automatic logic [N-1:0] expect_out(logic [N-1:0] en, logic stp_n, logic pd_low);
        return pd_low ? '0 : (en & (FREE | {N{stp_n}}));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // value seen in the middle of the next high phase
    task automatic sample(output logic [N-1:0] v, output logic r);
        @(posedge clk);
        #1.25;
        v = gclk;
        r = pd_ready;
    endtask

    task automatic drive_slot();
        @(negedge clk);
        #1;
    endtask

    for (genvar g = 0; g < N; g++) begin : g_mon
        realtime t_rise = -1.0;
        always @(posedge gclk[g]) t_rise = $realtime;
        always @(negedge gclk[g]) begin
            if (rst_n && t_rise >= 0.0) begin
                checks++;
                if ($realtime - t_rise < HALF - 0.01) begin
                    errors++;
                    $display("FAIL R2 out%0d pulse actual=%0t expected>=%0t", g,
                             $realtime - t_rise, HALF);
                end
            end
        end
    end

    initial begin
        #(200000 * 2 * HALF);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        logic r;
        logic [31:0] rnd;
        int lat;
        bit seen;
        rnd = $urandom(32'd4242);

        // R7 reset state
        repeat (3) @(posedge clk);
        #1.25;
        check("R7 gclk", 32'(gclk), 32'(0));
        check("R7 pd_ready", 32'(pd_ready), 32'(0));
        drive_slot();
        rst_n = 1'b1;
        repeat (4) sample(v, r);

        // R8 all enabled, running
        sample(v, r);
        check("R8 all run", 32'(v), 32'({N{1'b1}}));

        // R1 stop latency
        drive_slot();
        stop_n = 1'b0;
        lat = 0;
        for (int c = 1; c <= 6; c++) begin
            sample(v, r);
            if (lat == 0 && v[1] == 1'b0) lat = c;
        end
        check("R1 stop latency", 32'(lat), 32'(3));
        check("R3 free while stopped", 32'(v), 32'(FREE));

        // R1 restart latency
        drive_slot();
        stop_n = 1'b1;
        lat = 0;
        for (int c = 1; c <= 6; c++) begin
            sample(v, r);
            if (lat == 0 && v[1] == 1'b1) lat = c;
        end
        check("R1 restart latency", 32'(lat), 32'(3));

        // R4 disabled free-running output
        drive_slot();
        en_mask = 4'b1110;
        repeat (3) sample(v, r);
        check("R4 disabled low", 32'(v), 32'(4'b1110));

        // random mix R3 R4 R8
        for (int it = 0; it < 40; it++) begin
            rnd = $urandom();
            drive_slot();
            en_mask = rnd[N-1:0];
            stop_n = rnd[8];
            repeat (5) sample(v, r);
            check("R3/R4/R8 random", 32'(v), 32'(expect_out(en_mask, stop_n, 1'b0)));
            sample(v, r);
            check("R3/R4/R8 random", 32'(v), 32'(expect_out(en_mask, stop_n, 1'b0)));
        end

        // R5 power-down sequence
        drive_slot();
        en_mask = '1;
        stop_n = 1'b1;
        repeat (4) sample(v, r);
        drive_slot();
        pd_n = 1'b0;
        seen = 1'b0;
        for (int c = 1; c <= 8; c++) begin
            sample(v, r);
            if (r && !seen) begin
                seen = 1'b1;
                check("R5 quiet when ready", 32'(v), 32'(0));
            end
        end
        check("R5 ready raised", 32'(seen), 32'(1));

        // R6 stop ignored in power-down
        drive_slot();
        stop_n = 1'b0;
        repeat (4) sample(v, r);
        check("R6 stop ignored", 32'(v), 32'(0));
        drive_slot();
        stop_n = 1'b1;
        repeat (4) sample(v, r);
        check("R6 still low", 32'(v), 32'(0));
        check("R6 ready held", 32'(r), 32'(1));

        // R6 resume
        drive_slot();
        pd_n = 1'b1;
        repeat (6) sample(v, r);
        check("R6 resume out", 32'(v), 32'(expect_out(en_mask, stop_n, 1'b0)));
        check("R6 ready low", 32'(r), 32'(0));

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule